// File: doc/BRIEF.md
# SPI FIFO Word-Packing Data Port

This block sits between a 32-bit register bus and the byte-wide transmit and receive FIFOs of a SPI master. Software writes bytes to send through a data location and reads received bytes back through another. A single control flag turns on word packing. While it is set, one 32-bit access to the word location moves four FIFO bytes at once, so bulk transfers take a quarter of the bus accesses. The serial engine sits on the far side. It takes transmit bytes and delivers receive bytes through a plain valid/take and ready/put byte handshake.

The block also builds the status word and the interrupt output. The empty and full flags follow the active access granularity. Software polls the receive-empty flag before each read and the transmit-full flag before each write. Accesses that ignore those flags are handled safely: a read returns zero, and a write is dropped and recorded in a sticky overflow bit. The two completion bits and the overflow bit are sticky, and software clears them by writing 1 to them.

Register locations on `bus_addr`: 0 control (bit 0 = word packing on), 1 interrupt enable (bits 5:0), 2 status, 3 byte data, 4 word data. Any other address reads as zero.

Top module: `spi_fifo_port`

## Requirements
- R1: A write to the byte data location (address 3) pushes only bits [7:0] into the transmit FIFO. A read from it pops one byte and returns that byte in bits [7:0], with all upper bits zero.
- R2: With the control flag (address 0, bit 0) set, a write to the word location (address 4) pushes four bytes, bits [7:0] first and bits [31:24] last. A read from it pops four bytes packed in the same little-endian order.
- R3: With the control flag clear, the word location behaves exactly like the byte location.
- R4: Status bit positions are: 0 transmit done, 1 receive done, 2 receive data available, 3 transmit space available, 4 receive empty, 5 transmit full, 6 overflow, 7 engine idle (taken from `eng_idle`), 8 word packing active. Bit 2 is the inverse of bit 4, and bit 3 is the inverse of bit 5.
- R5: In byte mode, receive empty means zero bytes held and transmit full means zero free entries. In word mode, receive empty means fewer than four bytes held and transmit full means fewer than four free entries.
- R6: A data read that asks for more bytes than the receive FIFO holds (1 for a byte access, 4 for a packed access) returns zero and pops nothing.
- R7: A data write that needs more free entries than the transmit FIFO has is dropped entirely and sets status bit 6.
- R8: Status bits 0 and 1 are set by pulses on `eng_tx_done` and `eng_rx_done`, and bit 6 by an overflow. Writing 1 to bit 0, 1 or 6 of the status location clears that bit, and a set in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit among 5:0 is set and the same bit is set in the interrupt-enable register. The enable register reads back what was written to bits 5:0.
- R10: `eng_tx_valid` is high while the transmit FIFO holds a byte, and `eng_tx_byte` gives bytes in push order. `eng_rx_ready` is low only when the receive FIFO is full, and a put while it is low is ignored.
- R11: After reset both FIFOs are empty, word packing is off, the interrupt enables and sticky bits are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register location select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; data popped at the edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| eng_tx_valid | output | 1 | Transmit FIFO holds a byte |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Engine takes the oldest transmit byte |
| eng_rx_ready | output | 1 | Receive FIFO can accept a byte |
| eng_rx_byte | input | 8 | Byte received by the engine |
| eng_rx_put | input | 1 | Engine delivers `eng_rx_byte` |
| eng_tx_done | input | 1 | Pulse: engine finished transmitting |
| eng_rx_done | input | 1 | Pulse: engine finished receiving |
| eng_idle | input | 1 | Engine is idle and ready for a new sequence |
| irq | output | 1 | Masked interrupt request |

## Verification
The data path is exercised with a table of packed and single-byte values in alternating modes. Each value is sent out through the engine side and looped back in through the bus. Asymmetric values such as 0x44332211 expose byte-order swaps, and values with set upper bits in byte mode expose a leak of bits above [7:0]. Directed runs fill the transmit FIFO to exactly full and past it in both granularities. They also leave three receive bytes, which tells word-granularity flags from byte-granularity ones and tests reads that must not pop. A status clear is made to coincide with a completion pulse to show that the set wins.

// File: rtl/spi_fifo_port_pkg.sv
package spi_fifo_port_pkg;

   typedef enum logic [2:0] {
      LOC_CTRL = 3'd0,
      LOC_IEN  = 3'd1,
      LOC_STAT = 3'd2,
      LOC_BYTE = 3'd3,
      LOC_WORD = 3'd4
   } port_loc_e;

   localparam int ST_TX_DONE  = 0;
   localparam int ST_RX_DONE  = 1;
   localparam int ST_RX_AVAIL = 2;
   localparam int ST_TX_AVAIL = 3;
   localparam int ST_RX_EMPTY = 4;
   localparam int ST_TX_FULL  = 5;
   localparam int ST_OVERFLOW = 6;
   localparam int ST_IDLE     = 7;
   localparam int ST_WORD     = 8;
   localparam int STAT_W      = 9;
   localparam int IEN_W       = 6;

endpackage

// File: rtl/spi_lane_fifo.sv
module spi_lane_fifo #(
   parameter int DEPTH  = 8,
   parameter int PUSH_L = 1,
   parameter int POP_L  = 1,
   localparam int AW  = $clog2(DEPTH),
   localparam int CW  = $clog2(DEPTH + 1),
   localparam int PNW = $clog2(PUSH_L + 1),
   localparam int QNW = $clog2(POP_L + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PNW-1:0]      push_n,
   input  logic [PUSH_L*8-1:0] push_data,
   input  logic [QNW-1:0]      pop_n,
   output logic [POP_L*8-1:0]  peek,
   output logic [CW-1:0]       count
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_lane_fifo: DEPTH must be a power of two, at least 4");
      end
      if (PUSH_L > DEPTH || POP_L > DEPTH) begin : g_bad_lanes
         $error("spi_lane_fifo: lane count exceeds DEPTH");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_n);
         rd_ptr <= rd_ptr + AW'(pop_n);
         count  <= count + CW'(push_n) - CW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PUSH_L; i++) begin
         if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
      end
   end

   generate
      for (genvar j = 0; j < POP_L; j++) begin : g_peek
         assign peek[j*8 +: 8] = mem[rd_ptr + AW'(j)];
      end
   endgenerate

   // R7: the port never pushes past the free space
   assert_push_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(push_n) <= DEPTH - int'(count));
   // R6: the port never pops more than is held
   assert_pop_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop_n) <= int'(count));

endmodule

// File: rtl/spi_sticky_bits.sv
module spi_sticky_bits #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end

   // R8: a set always lands, even against a same-cycle clear
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/spi_fifo_port.sv
module spi_fifo_port
   import spi_fifo_port_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              eng_tx_valid,
   output logic [7:0]        eng_tx_byte,
   input  logic              eng_tx_take,
   output logic              eng_rx_ready,
   input  logic [7:0]        eng_rx_byte,
   input  logic              eng_rx_put,
   input  logic              eng_tx_done,
   input  logic              eng_rx_done,
   input  logic              eng_idle,
   output logic              irq
);

   localparam int LANES = DATA_W / 8;
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int NW    = $clog2(LANES + 1);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16 || LANES > DEPTH) begin : g_bad_width
         $error("spi_fifo_port: DATA_W must be whole bytes, at least 2, not above DEPTH");
      end
   endgenerate

   logic              word_mode;
   logic [IEN_W-1:0]  ien_q;
   logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
   logic [NW-1:0]     tx_push_n, rx_pop_n, wr_need, rd_need;
   logic [DATA_W-1:0] rx_peek;
   logic              wr_wide, wr_one, rd_wide, rd_one, wr_ok, rd_ok, ovf_evt;
   logic              tx_take_ok, rx_put_ok, tx_full_g, rx_empty_g;
   logic [2:0]        stk_set, stk_clr, stk_q;
   logic [STAT_W-1:0] status_w;

   // access decode and flow guards
   always_comb begin
      wr_wide = bus_wr && bus_addr == LOC_WORD && word_mode;
      wr_one  = bus_wr && (bus_addr == LOC_BYTE || (bus_addr == LOC_WORD && !word_mode));
      rd_wide = bus_rd && bus_addr == LOC_WORD && word_mode;
      rd_one  = bus_rd && (bus_addr == LOC_BYTE || (bus_addr == LOC_WORD && !word_mode));
      wr_need = wr_wide ? NW'(LANES) : NW'(wr_one);
      rd_need = rd_wide ? NW'(LANES) : NW'(rd_one);
      tx_free = CW'(DEPTH) - tx_cnt;
      wr_ok   = (wr_wide || wr_one) && int'(tx_free) >= int'(wr_need);
      rd_ok   = (rd_wide || rd_one) && int'(rx_cnt) >= int'(rd_need);
      ovf_evt = (wr_wide || wr_one) && !wr_ok;
      tx_push_n = wr_ok ? wr_need : '0;
      rx_pop_n  = rd_ok ? rd_need : '0;
   end

   assign eng_tx_valid = tx_cnt != '0;
   assign eng_rx_ready = rx_cnt != CW'(DEPTH);
   assign tx_take_ok   = eng_tx_take && eng_tx_valid;
   assign rx_put_ok    = eng_rx_put && eng_rx_ready;

   spi_lane_fifo #(.DEPTH(DEPTH), .PUSH_L(LANES), .POP_L(1)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_n(tx_push_n), .push_data(bus_wdata),
      .pop_n(tx_take_ok), .peek(eng_tx_byte), .count(tx_cnt)
   );

   spi_lane_fifo #(.DEPTH(DEPTH), .PUSH_L(1), .POP_L(LANES)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_n(rx_put_ok), .push_data(eng_rx_byte),
      .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
   );

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_mode <= 1'b0;
         ien_q     <= '0;
      end else if (bus_wr) begin
         if (bus_addr == LOC_CTRL) word_mode <= bus_wdata[0];
         if (bus_addr == LOC_IEN)  ien_q     <= bus_wdata[IEN_W-1:0];
      end
   end

   // sticky bits: [0] tx done, [1] rx done, [2] overflow
   assign stk_set = {ovf_evt, eng_rx_done, eng_tx_done};
   assign stk_clr = (bus_wr && bus_addr == LOC_STAT) ?
                    {bus_wdata[ST_OVERFLOW], bus_wdata[ST_RX_DONE], bus_wdata[ST_TX_DONE]} : 3'b000;

   spi_sticky_bits #(.N(3)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stk_clr), .q(stk_q)
   );

   always_comb begin
      tx_full_g  = word_mode ? (int'(tx_free) < LANES) : (tx_free == '0);
      rx_empty_g = word_mode ? (int'(rx_cnt) < LANES)  : (rx_cnt == '0);
      status_w              = '0;
      status_w[ST_TX_DONE]  = stk_q[0];
      status_w[ST_RX_DONE]  = stk_q[1];
      status_w[ST_RX_AVAIL] = !rx_empty_g;
      status_w[ST_TX_AVAIL] = !tx_full_g;
      status_w[ST_RX_EMPTY] = rx_empty_g;
      status_w[ST_TX_FULL]  = tx_full_g;
      status_w[ST_OVERFLOW] = stk_q[2];
      status_w[ST_IDLE]     = eng_idle;
      status_w[ST_WORD]     = word_mode;
   end

   assign irq = |(status_w[IEN_W-1:0] & ien_q);

   // read data
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         LOC_CTRL: bus_rdata = DATA_W'(word_mode);
         LOC_IEN:  bus_rdata = DATA_W'(ien_q);
         LOC_STAT: bus_rdata = DATA_W'(status_w);
         LOC_BYTE, LOC_WORD: begin
            if (rd_ok) bus_rdata = rd_wide ? rx_peek : DATA_W'(rx_peek[7:0]);
         end
         default:  bus_rdata = '0;
      endcase
   end

   // R6: empty byte read gives zero
   assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == LOC_BYTE && rx_cnt == '0) |-> bus_rdata == '0);
   // R7: write into a full FIFO leaves it full and flags overflow
   assert_full_write_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == LOC_BYTE && tx_cnt == CW'(DEPTH) && !eng_tx_take)
      |=> (tx_cnt == CW'(DEPTH) && stk_q[2]));
   // R10: a put while full changes nothing in the receive count
   assert_rx_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CW'(DEPTH) && !bus_rd) |=> rx_cnt == CW'(DEPTH));

endmodule

// File: tb/spi_fifo_port_test.sv
module spi_fifo_port_test;

   localparam int DW = 32;
   localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STAT = 3'd2,
                          A_BYTE = 3'd3, A_WORD = 3'd4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic bus_wr = 0, bus_rd = 0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic eng_tx_valid, eng_rx_ready, irq;
   logic [7:0] eng_tx_byte, eng_rx_byte = '0;
   logic eng_tx_take = 0, eng_rx_put = 0, eng_tx_done = 0, eng_rx_done = 0, eng_idle = 1;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_fifo_port #(.DATA_W(DW), .DEPTH(8)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid),
      .eng_tx_byte(eng_tx_byte), .eng_tx_take(eng_tx_take), .eng_rx_ready(eng_rx_ready),
      .eng_rx_byte(eng_rx_byte), .eng_rx_put(eng_rx_put), .eng_tx_done(eng_tx_done),
      .eng_rx_done(eng_rx_done), .eng_idle(eng_idle), .irq(irq)
   );

   // {word mode, data}
   localparam logic [32:0] VEC [6] = '{
      {1'b1, 32'h44332211}, {1'b0, 32'hABCDEF5A}, {1'b1, 32'h80FF0001},
      {1'b0, 32'h000000C3}, {1'b1, 32'hDEADBEEF}, {1'b0, 32'h12345678}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic br(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic take(output logic v, output logic [7:0] b);
      @(negedge clk); v = eng_tx_valid; b = eng_tx_byte; eng_tx_take = 1;
      @(negedge clk); eng_tx_take = 0;
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); eng_rx_byte = b; eng_rx_put = 1;
      @(negedge clk); eng_rx_put = 0;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
      finished = 1;
      $finish;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [31:0] d;
      logic v;
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R11 reset state; R4 layout: rx empty, tx avail, idle
      br(A_STAT, d); chk("R11 reset status", d, 32'h098);
      chk("R11 irq low", {31'b0, irq}, 0);
      chk("R11 tx not valid", {31'b0, eng_tx_valid}, 0);
      chk("R11 rx ready", {31'b0, eng_rx_ready}, 1);
      br(A_CTRL, d); chk("R11 word mode off", d, 0);

      // table: loop each value out through the engine and back in
      foreach (VEC[i]) begin
         int n;
         logic [31:0] val;
         val = VEC[i][31:0];
         n = VEC[i][32] ? 4 : 1;
         bw(A_CTRL, {31'b0, VEC[i][32]});
         bw(A_WORD, val);
         for (int k = 0; k < n; k++) begin
            take(v, b);
            chk(VEC[i][32] ? "R2 tx byte order" : "R3 byte-mode word write", {v, b}, {1'b1, val[8*k +: 8]});
         end
         chk("R10 tx drained", {31'b0, eng_tx_valid}, 0);
         for (int k = 0; k < n; k++) put(val[8*k +: 8]);
         br(A_WORD, d);
         chk(VEC[i][32] ? "R2 rx packed read" : "R3 byte-mode word read", d,
             VEC[i][32] ? val : {24'b0, val[7:0]});
      end
      bw(A_CTRL, 0);

      // R1 byte location keeps only [7:0]
      bw(A_BYTE, 32'hFFFFFF7E);
      take(v, b); chk("R1 byte write", {v, b}, 9'h17E);
      chk("R1 single byte only", {31'b0, eng_tx_valid}, 0);
      put(8'h9C); br(A_BYTE, d); chk("R1 byte read zero-extended", d, 32'h9C);

      // R6 empty read returns zero, pops nothing
      br(A_BYTE, d); chk("R6 empty byte read", d, 0);
      bw(A_CTRL, 1);
      put(8'hA1); put(8'hA2); put(8'hA3);
      br(A_WORD, d); chk("R6 short packed read", d, 0);
      br(A_STAT, d); chk("R5 word rx empty with 3 bytes", d & 32'h14, 32'h10);
      bw(A_CTRL, 0);
      br(A_STAT, d); chk("R5 byte rx not empty with 3 bytes", d & 32'h114, 32'h04);
      br(A_BYTE, d); chk("R6 nothing popped 1", d, 32'hA1);
      br(A_BYTE, d); chk("R6 nothing popped 2", d, 32'hA2);
      br(A_BYTE, d); chk("R6 nothing popped 3", d, 32'hA3);

      // R7 byte-mode overflow
      for (int k = 0; k < 8; k++) bw(A_BYTE, 32'h10 + k);
      br(A_STAT, d); chk("R4 R5 tx full byte mode", d, 32'h0B0);
      bw(A_BYTE, 32'hEE);
      br(A_STAT, d); chk("R7 overflow set", d, 32'h0F0);
      for (int k = 0; k < 8; k++) begin
         take(v, b); chk("R7 R10 kept order", {v, b}, {1'b1, 8'h10 + 8'(k)});
      end
      chk("R7 dropped byte absent", {31'b0, eng_tx_valid}, 0);
      bw(A_STAT, 32'h40);
      br(A_STAT, d); chk("R8 overflow cleared", d & 32'h40, 0);

      // R5/R7 word-granularity full
      bw(A_CTRL, 1);
      for (int k = 0; k < 5; k++) bw(A_BYTE, 32'h20 + k);
      br(A_STAT, d); chk("R5 word tx full with 3 free", d & 32'h128, 32'h120);
      bw(A_WORD, 32'h99999999);
      br(A_STAT, d); chk("R7 packed write dropped", d & 32'h40, 32'h40);
      for (int k = 0; k < 5; k++) begin
         take(v, b); chk("R7 word drop kept contents", {v, b}, {1'b1, 8'h20 + 8'(k)});
      end
      chk("R7 no packed bytes entered", {31'b0, eng_tx_valid}, 0);
      bw(A_STAT, 32'h40);
      bw(A_CTRL, 0);

      // R8 sticky done bits and write-1-to-clear
      @(negedge clk); eng_tx_done = 1; @(negedge clk); eng_tx_done = 0;
      @(negedge clk); eng_rx_done = 1; @(negedge clk); eng_rx_done = 0;
      br(A_STAT, d); chk("R8 both done sticky", d & 32'h43, 32'h03);
      bw(A_STAT, 32'h1);
      br(A_STAT, d); chk("R8 clear tx done only", d & 32'h43, 32'h02);
      @(negedge clk); bus_addr = A_STAT; bus_wdata = 32'h3; bus_wr = 1; eng_tx_done = 1;
      @(negedge clk); bus_wr = 0; eng_tx_done = 0;
      br(A_STAT, d); chk("R8 set wins over clear", d & 32'h43, 32'h01);
      bw(A_STAT, 32'h3);
      br(A_STAT, d); chk("R8 all cleared", d & 32'h43, 0);

      // R4 idle bit follows input
      eng_idle = 0;
      br(A_STAT, d); chk("R4 idle bit low", d & 32'h80, 0);
      eng_idle = 1;

      // R9 interrupt masking
      chk("R9 no enables no irq", {31'b0, irq}, 0);
      bw(A_IEN, 32'hFFFF_FF10);
      br(A_IEN, d); chk("R9 enable readback", d, 32'h10);
      @(negedge clk); chk("R9 rx empty enabled", {31'b0, irq}, 1);
      bw(A_IEN, 32'h04);
      @(negedge clk); chk("R9 rx avail masked while empty", {31'b0, irq}, 0);
      put(8'h66);
      @(negedge clk); chk("R9 rx avail raises irq", {31'b0, irq}, 1);
      br(A_BYTE, d); chk("R9 drain", d, 32'h66);
      bw(A_IEN, 0);

      // R10 rx full handshake
      for (int k = 0; k < 8; k++) put(8'h30 + 8'(k));
      chk("R10 rx ready low when full", {31'b0, eng_rx_ready}, 0);
      put(8'hFF);
      for (int k = 0; k < 8; k++) begin
         br(A_BYTE, d); chk("R10 rx order", d, 32'h30 + k);
      end
      br(A_BYTE, d); chk("R10 put while full ignored", d, 0);

      summary();
   end

endmodule